// File: doc/BRIEF.md
# Four-Channel Code Register and Load Controller

This block sits between a serial word receiver and four converter channels. Each incoming 16-bit word carries a channel address, a power-down flag, a speed flag and a 10-bit code. The block keeps two register ranks for every channel. The first rank is a holding stage that takes the fields of each accepted word. The second rank is an active stage that drives the channel outputs.

A synchronous, active-low load input controls the move from the holding stage to the active stage. While load is held low, every write reaches its channel's outputs one clock later. While load is held high, the outputs stay frozen and the holding stage collects new values. The first clock edge that samples load low then copies all four channels at the same time.

A separate active-low global power-down input forces every channel's power-down output on. It does not touch any stored code or flag, so when it is released the earlier state returns.

Words arrive on a valid/ready stream. The block never applies back-pressure: ready is always high, so a word is taken on every clock edge where valid is high, including back-to-back cycles. The load and global power-down inputs are plain level controls.

Top module: `qcl_quad_latch`

## Requirements
- R1: The word fields are: bits 15:14 channel address, bit 13 power-down flag, bit 12 speed flag, bits 11:2 the code (bit 11 is its MSB). Bits 1:0 have no effect on any output.
- R2: Address 0 selects channel 0 (code_out[9:0], bit 0 of the flag outputs). Address 1 selects channel 1, address 2 channel 2 and address 3 channel 3, with code_out slice i*10 +: 10 belonging to channel i.
- R3: A power-down flag of 1 drives pd_out of the addressed channel to 1 once the word is transferred. A flag of 0 drives it to 0 (when the global power-down is released).
- R4: A speed flag of 1 drives fast_out of the addressed channel to 1 once the word is transferred. A flag of 0 drives it to 0.
- R5: A word accepted at clock edge k, with load_n low at edge k+1, appears on the addressed channel's outputs just after edge k+1.
- R6: An accepted word changes only the addressed channel. The other three channels keep their outputs.
- R7: At every edge where load_n is sampled high, code_out, fast_out and the stored power-down flags do not change.
- R8: At the first edge that samples load_n low, all four channels take their latest holding values together. When a channel was written more than once while load was high, the last write wins.
- R9: After reset, every code, power-down flag and speed flag reads zero.
- R10: While pwrdn_n is low, all four pd_out bits are 1 in the same cycle, whatever the stored flags.
- R11: Driving pwrdn_n low does not modify stored codes or flags. Writes and transfers continue while it is low, and releasing it brings back the stored pd flags in the same cycle.
- R12: word_ready is always 1, and words on consecutive cycles are all taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Word present on word_data |
| word_ready | output | 1 | Always 1; block accepts every word |
| word_data | input | 16 | Address, flags, code and two ignored bits |
| load_n | input | 1 | Active-low transfer of holding into active registers |
| pwrdn_n | input | 1 | Active-low global power-down override |
| code_out | output | 40 | Four 10-bit active codes, channel i at bits i*10 +: 10 |
| pd_out | output | 4 | Per-channel power-down, forced high by pwrdn_n low |
| fast_out | output | 4 | Per-channel fast-settling select |

## Verification
A word taken at edge k lands in holding at edge k. With load_n low, it reaches the outputs at edge k+1. The scoreboard therefore marks that entry due two negative edges after the cycle that drove it. A load_n falling step is due one cycle after it is driven, because the copy happens on the next edge. A global power-down change is combinational and is checked in the same cycle it is driven. Frozen-output checks are taken several cycles after writes made with load high, against values the bench has not yet moved to its active model.

// File: rtl/qcl_pkg.sv
package qcl_pkg;
  localparam int unsigned QCL_NUM_CH = 4;
  localparam int unsigned QCL_CODE_W = 10;
  localparam int unsigned QCL_WORD_W = 16;
  localparam int unsigned QCL_FLAG_W = 2;

  function automatic int unsigned qcl_addr_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/qcl_word_decode.sv
module qcl_word_decode
  import qcl_pkg::*;
#(
  parameter int unsigned NUM_CH = QCL_NUM_CH,
  parameter int unsigned CODE_W = QCL_CODE_W,
  parameter int unsigned WORD_W = QCL_WORD_W
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic [NUM_CH-1:0] wr_en,
  output logic [CODE_W-1:0] wr_code,
  output logic              wr_pd,
  output logic              wr_fast
);
  localparam int unsigned ADDR_W   = qcl_addr_w(NUM_CH);
  localparam int unsigned ADDR_LSB = WORD_W - ADDR_W;
  localparam int unsigned PD_POS   = ADDR_LSB - 1;
  localparam int unsigned SPD_POS  = ADDR_LSB - 2;
  localparam int unsigned CODE_LSB = ADDR_LSB - QCL_FLAG_W - CODE_W;

  logic [ADDR_W-1:0] addr;
  logic              unused_pad;

  assign addr    = word[ADDR_LSB +: ADDR_W];
  assign wr_pd   = word[PD_POS];
  assign wr_fast = word[SPD_POS];
  assign wr_code = word[CODE_LSB +: CODE_W];

  generate
    if (CODE_LSB > 0) begin : g_pad
      assign unused_pad = ^word[CODE_LSB-1:0];
    end else begin : g_nopad
      assign unused_pad = 1'b0;
    end
  endgenerate

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign wr_en[i] = valid && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/qcl_chan_slot.sv
module qcl_chan_slot #(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_pd,
  input  logic              wr_fast,
  input  logic              xfer,
  output logic [CODE_W-1:0] act_code,
  output logic              act_pd,
  output logic              act_fast
);
  logic [CODE_W-1:0] hold_code;
  logic              hold_pd;
  logic              hold_fast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_code <= '0;
      hold_pd   <= 1'b0;
      hold_fast <= 1'b0;
    end else if (wr_en) begin
      hold_code <= wr_code;
      hold_pd   <= wr_pd;
      hold_fast <= wr_fast;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= '0;
      act_pd   <= 1'b0;
      act_fast <= 1'b0;
    end else if (xfer) begin
      act_code <= hold_code;
      act_pd   <= hold_pd;
      act_fast <= hold_fast;
    end
  end
endmodule

// File: rtl/qcl_pd_gate.sv
module qcl_pd_gate #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] act_pd,
  input  logic              global_pd_n,
  output logic [NUM_CH-1:0] pd_out
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_gate
    assign pd_out[i] = act_pd[i] | ~global_pd_n;
  end
endmodule

// File: rtl/qcl_quad_latch.sv
module qcl_quad_latch
  import qcl_pkg::*;
#(
  parameter int unsigned NUM_CH = QCL_NUM_CH,
  parameter int unsigned CODE_W = QCL_CODE_W,
  parameter int unsigned WORD_W = QCL_WORD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     word_valid,
  output logic                     word_ready,
  input  logic [WORD_W-1:0]        word_data,
  input  logic                     load_n,
  input  logic                     pwrdn_n,
  output logic [NUM_CH*CODE_W-1:0] code_out,
  output logic [NUM_CH-1:0]        pd_out,
  output logic [NUM_CH-1:0]        fast_out
);
  logic [NUM_CH-1:0] wr_en;
  logic [CODE_W-1:0] wr_code;
  logic              wr_pd;
  logic              wr_fast;
  logic [NUM_CH-1:0] act_pd;
  logic              xfer;

  assign word_ready = 1'b1;
  assign xfer       = ~load_n;

  qcl_word_decode #(
    .NUM_CH(NUM_CH), .CODE_W(CODE_W), .WORD_W(WORD_W)
  ) u_dec (
    .valid  (word_valid & word_ready),
    .word   (word_data),
    .wr_en  (wr_en),
    .wr_code(wr_code),
    .wr_pd  (wr_pd),
    .wr_fast(wr_fast)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    qcl_chan_slot #(.CODE_W(CODE_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en[i]),
      .wr_code (wr_code),
      .wr_pd   (wr_pd),
      .wr_fast (wr_fast),
      .xfer    (xfer),
      .act_code(code_out[i*CODE_W +: CODE_W]),
      .act_pd  (act_pd[i]),
      .act_fast(fast_out[i])
    );
  end

  qcl_pd_gate #(.NUM_CH(NUM_CH)) u_gate (
    .act_pd     (act_pd),
    .global_pd_n(pwrdn_n),
    .pd_out     (pd_out)
  );
endmodule

// File: rtl/qcl_quad_latch_chk.sv
module qcl_quad_latch_chk
  import qcl_pkg::*;
#(
  parameter int unsigned NUM_CH = QCL_NUM_CH,
  parameter int unsigned CODE_W = QCL_CODE_W,
  parameter int unsigned WORD_W = QCL_WORD_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     word_valid,
  input logic                     word_ready,
  input logic [WORD_W-1:0]        word_data,
  input logic                     load_n,
  input logic                     pwrdn_n,
  input logic [NUM_CH*CODE_W-1:0] code_out,
  input logic [NUM_CH-1:0]        pd_out,
  input logic [NUM_CH-1:0]        fast_out
);
  localparam int unsigned ADDR_W   = qcl_addr_w(NUM_CH);
  localparam int unsigned ADDR_LSB = WORD_W - ADDR_W;
  localparam int unsigned PD_POS   = ADDR_LSB - 1;
  localparam int unsigned SPD_POS  = ADDR_LSB - 2;
  localparam int unsigned CODE_LSB = ADDR_LSB - QCL_FLAG_W - CODE_W;

  AST_LOAD_HIGH_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> ($stable(code_out) && $stable(fast_out))); // R7

  AST_GLOBAL_PD_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |-> (&pd_out)); // R10

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_WRITE_THROUGH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_ready && !load_n && word_data[ADDR_LSB +: ADDR_W] == ADDR_W'(i))
      ##1 !load_n
      |=> (code_out[i*CODE_W +: CODE_W] == $past(word_data[CODE_LSB +: CODE_W], 2))); // R5

    AST_WRITE_THROUGH_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_ready && !load_n && word_data[ADDR_LSB +: ADDR_W] == ADDR_W'(i))
      ##1 !load_n
      |=> (fast_out[i] == $past(word_data[SPD_POS], 2))); // R4

    AST_WRITE_THROUGH_PD: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_ready && !load_n && word_data[ADDR_LSB +: ADDR_W] == ADDR_W'(i))
      ##1 !load_n
      |=> (pd_out[i] == ($past(word_data[PD_POS], 2) || !pwrdn_n))); // R3
  end
endmodule

bind qcl_quad_latch qcl_quad_latch_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .WORD_W(WORD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .word_valid(word_valid),
  .word_ready(word_ready),
  .word_data (word_data),
  .load_n    (load_n),
  .pwrdn_n   (pwrdn_n),
  .code_out  (code_out),
  .pd_out    (pd_out),
  .fast_out  (fast_out)
);

// File: tb/tb_qcl_quad_latch.sv
module tb_qcl_quad_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [15:0] word_data = '0;
  logic        load_n = 1'b0;
  logic        pwrdn_n = 1'b1;
  logic [39:0] code_out;
  logic [3:0]  pd_out;
  logic [3:0]  fast_out;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    int          ch;
    logic [9:0]  code;
    logic        pd;
    logic        fs;
    string       tag;
  } item_t;
  item_t sb[$];

  logic [9:0] hcode[4];
  logic        hpd[4];
  logic        hfs[4];
  logic [9:0] acode[4];
  logic        apd[4];
  logic        afs[4];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qcl_quad_latch dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .load_n(load_n), .pwrdn_n(pwrdn_n),
    .code_out(code_out), .pd_out(pd_out), .fast_out(fast_out)
  );

  function automatic logic [15:0] mk(int ch, bit pd, bit fs, int code, int junk);
    return {ch[1:0], pd, fs, code[9:0], junk[1:0]};
  endfunction

  task automatic push_ch(int due, int ch, string tag);
    item_t it;
    it.due = due; it.ch = ch; it.code = acode[ch];
    it.pd = apd[ch] | ~pwrdn_n; it.fs = afs[ch]; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic push_all(int due, string tag);
    for (int c = 0; c < 4; c++) push_ch(due, c, tag);
  endtask

  // monitor: compare due items at the falling edge
  always @(negedge clk) begin
    for (int k = sb.size() - 1; k >= 0; k--) begin
      if (sb[k].due == cyc) begin
        checks++;
        if (code_out[sb[k].ch*10 +: 10] !== sb[k].code || pd_out[sb[k].ch] !== sb[k].pd ||
            fast_out[sb[k].ch] !== sb[k].fs) begin
          failures++;
          $display("FAIL %s ch%0d: actual code=%h pd=%b fast=%b expected code=%h pd=%b fast=%b",
                   sb[k].tag, sb[k].ch, code_out[sb[k].ch*10 +: 10], pd_out[sb[k].ch],
                   fast_out[sb[k].ch], sb[k].code, sb[k].pd, sb[k].fs);
        end
        sb.delete(k);
      end
    end
  end

  task automatic check_ready(string tag);
    checks++;
    if (word_ready !== 1'b1) begin
      failures++;
      $display("FAIL %s: actual word_ready=%b expected 1", tag, word_ready);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic send(int ch, bit pd, bit fs, int code, int junk, string tag);
    @(posedge clk); #2;
    word_valid = 1'b1;
    word_data  = mk(ch, pd, fs, code, junk);
    hcode[ch] = code[9:0]; hpd[ch] = pd; hfs[ch] = fs;
    if (!load_n) begin
      acode[ch] = hcode[ch]; apd[ch] = hpd[ch]; afs[ch] = hfs[ch];
      push_ch(cyc + 2, ch, tag);
    end
    @(posedge clk); #2;
    word_valid = 1'b0;
  endtask

  // two words on consecutive cycles, load_n low
  task automatic burst2(int ca, int da, int cb, int db);
    @(posedge clk); #2;
    word_valid = 1'b1;
    word_data  = mk(ca, 0, 1, da, 1);
    hcode[ca] = da[9:0]; hpd[ca] = 0; hfs[ca] = 1;
    acode[ca] = hcode[ca]; apd[ca] = 0; afs[ca] = 1;
    push_ch(cyc + 2, ca, "R12");
    check_ready("R12");
    @(posedge clk); #2;
    word_data  = mk(cb, 1, 0, db, 2);
    hcode[cb] = db[9:0]; hpd[cb] = 1; hfs[cb] = 0;
    acode[cb] = hcode[cb]; apd[cb] = 1; afs[cb] = 0;
    push_ch(cyc + 2, cb, "R12");
    check_ready("R12");
    @(posedge clk); #2;
    word_valid = 1'b0;
  endtask

  task automatic set_load(bit v, string tag);
    @(posedge clk); #2;
    load_n = v;
    if (!v) begin
      for (int c = 0; c < 4; c++) begin
        acode[c] = hcode[c]; apd[c] = hpd[c]; afs[c] = hfs[c];
      end
      push_all(cyc + 1, tag);
    end
  endtask

  task automatic set_gpd(bit v, string tag);
    @(posedge clk); #2;
    pwrdn_n = v;
    push_all(cyc, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      hcode[c] = '0; hpd[c] = 0; hfs[c] = 0;
      acode[c] = '0; apd[c] = 0; afs[c] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    push_all(cyc, "R9");
    check_ready("R12");

    // write-through, one channel at a time (R1 R2 R3 R4 R5)
    send(0, 0, 1, 10'h155, 3, "R1");
    send(1, 1, 0, 10'h2AA, 0, "R2");
    send(2, 0, 1, 10'h3FF, 2, "R4");
    send(3, 1, 1, 10'h001, 1, "R3");
    idle(3);
    push_all(cyc, "R5");
    // only channel 1 changes (R6)
    send(1, 0, 1, 10'h0C3, 3, "R6");
    idle(2);
    push_all(cyc, "R6");

    // load held high: outputs frozen (R7)
    set_load(1, "R7");
    send(0, 1, 0, 10'h111, 0, "R7");
    send(2, 1, 0, 10'h222, 1, "R7");
    send(3, 0, 0, 10'h333, 2, "R7");
    send(3, 0, 1, 10'h2F0, 3, "R7");
    idle(3);
    push_all(cyc, "R7");
    idle(2);
    push_all(cyc, "R7");
    // simultaneous copy, last write wins on channel 3 (R8)
    set_load(0, "R8");
    idle(3);
    push_all(cyc, "R8");

    // global power-down override (R10 R11)
    set_gpd(0, "R10");
    send(0, 0, 0, 10'h0AB, 0, "R11");
    idle(2);
    push_all(cyc, "R10");
    set_gpd(1, "R11");
    idle(1);
    push_all(cyc, "R11");

    // back-to-back words (R12)
    burst2(2, 10'h155, 1, 10'h3C0);
    idle(3);
    push_all(cyc, "R12");

    idle(4);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard R5: actual %0d items pending, expected 0", sb.size());
    end
    finish_run();
  end
endmodule